// File: doc/BRIEF.md
# Five-Step Multicycle Processor Core

This block is a compact processor core that carries every instruction through the same five-cycle control sequence. The steps are: fetch, decode with operand read, arithmetic, memory access and register update. Each step leaves its result in a dedicated holding register, and the next step reads it from there. The registers are two operand latches, an ALU result, a store-data latch, a writeback latch and a saved return address. Only one path carries a step's work into the next, so the control logic stays a simple function of the step number and the opcode.

The core has one memory port for both instruction and data traffic. In the fetch step the port address comes from the program counter. When a load or store is in its memory step, the address comes from the ALU result register. Reads are combinational: the returned word must be valid in the cycle the read strobe is high. Instructions are 24 bits wide, data is 16 bits wide, and addresses are in bytes with one instruction per 4-byte slot. The core supports register add, add with immediate, load, store, unconditional branch, branch-if-equal and a call through a register that records its return address in a fixed link register.

Top module: `mc5_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the core presents a fetch at address 0 (`mem_rd`=1, `mem_wr`=0). Reset clears the program counter and all 16 registers to zero.
- R2: Every instruction takes exactly five cycles. Its fetch cycle drives `mem_addr` with the program counter and raises `mem_rd`. Steps 2, 3 and 5 raise no strobe. Unless the instruction redirects control, the next fetch is at the previous fetch address plus 4. The opcode is in bits [23:20].
- R3: Register add (opcode 1) writes reg[bits 15:12] + reg[bits 11:8], modulo 2^16, into reg[bits 19:16].
- R4: Add-immediate (opcode 2) writes reg[bits 15:12] plus the sign-extended 12-bit field in bits [11:0] into reg[bits 19:16].
- R5: Load (opcode 3) raises `mem_rd` in step 4 at address reg[bits 15:12] + sign-extended bits [11:0]. It writes the low 16 bits of the returned word into reg[bits 19:16].
- R6: Store (opcode 4) raises `mem_wr` in step 4 only. It drives reg[bits 19:16] on `mem_wdata` and reg[bits 15:12] + sign-extended bits [11:0] on `mem_addr`, and writes no register.
- R7: Unconditional branch (opcode 5) sets the next fetch address to the branch's own address + 4 + the sign-extended offset in bits [11:0].
- R8: Branch-if-equal (opcode 6) takes the R7 target when reg[bits 19:16] equals reg[bits 15:12]. Otherwise it falls through to the next slot.
- R9: Call (opcode 7) sets the next fetch address to reg[bits 15:12]. It writes its own address + 4 into register 15. The target is read before the link write, so a call through register 15 jumps to the old value.
- R10: Opcode 0 and opcodes 8 to 15 do nothing. They raise no strobe in step 4 and change no register.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle, and two writes never occur in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Byte address: program counter in fetch, ALU result in the data step |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` in the same cycle |
| mem_wr | output | 1 | Write strobe; memory captures `mem_wdata` at the rising edge |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 24 | Read data: a full instruction word, or a data word whose low 16 bits are used |

## Verification
The assertions follow the strobe pattern on every cycle. They keep an independent five-cycle phase count and check the following: a fetch in every first phase, silence in the second, third and fifth phases, writes only for store opcodes in the fourth phase, no traffic for undefined opcodes, no overlap of read and write, and a fetch from address zero right after reset. Arithmetic results, sign extension, branch decisions and the link value are visible only as addresses and data on the port. The bench therefore runs a reference model beside the core and compares every fetch address and every data access with it. At the end, a run of stores copies all sixteen registers to memory so that their final values can be checked.

// File: rtl/mc5_pkg.sv
package mc5_pkg;

  // Instruction word layout (format is fixed; sizes derive from it)
  localparam int INSTR_W = 24;
  localparam int OPC_W   = 4;
  localparam int RIDX_W  = 4;
  localparam int IMM_W   = 12;
  localparam int OPC_LSB = 20;
  localparam int F1_LSB  = 16;   // destination / store data / first compare
  localparam int F2_LSB  = 12;   // base / first addend / call target
  localparam int F3_LSB  = 8;    // second addend of register add

  localparam logic [OPC_W-1:0] OP_ADD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADDI = 4'd2;
  localparam logic [OPC_W-1:0] OP_LD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_ST   = 4'd4;
  localparam logic [OPC_W-1:0] OP_BR   = 4'd5;
  localparam logic [OPC_W-1:0] OP_BEQ  = 4'd6;
  localparam logic [OPC_W-1:0] OP_CALL = 4'd7;

  typedef enum logic [2:0] {
    S_FETCH  = 3'd0,
    S_DECODE = 3'd1,
    S_EXEC   = 3'd2,
    S_MEM    = 3'd3,
    S_WB     = 3'd4
  } step_e;

  function automatic logic writes_reg(input logic [OPC_W-1:0] op);
    return (op == OP_ADD) || (op == OP_ADDI) || (op == OP_LD) || (op == OP_CALL);
  endfunction

endpackage

// File: rtl/mc5_stepper.sv
module mc5_stepper
  import mc5_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output step_e step
);

  step_e step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= S_FETCH;
    end else begin
      case (step_q)
        S_FETCH:  step_q <= S_DECODE;
        S_DECODE: step_q <= S_EXEC;
        S_EXEC:   step_q <= S_MEM;
        S_MEM:    step_q <= S_WB;
        default:  step_q <= S_FETCH;
      endcase
    end
  end

  assign step = step_q;

endmodule

// File: rtl/mc5_regfile.sv
module mc5_regfile #(
  parameter int DATA_W = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rd_a_idx,
  input  logic [AW-1:0]     rd_b_idx,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int NREG = 1 << AW;

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we && (wr_idx == AW'(g))) begin
        regs[g] <= wr_data;
      end
    end
  end

  assign rd_a = regs[rd_a_idx];
  assign rd_b = regs[rd_b_idx];

endmodule

// File: rtl/mc5_alu.sv
module mc5_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] cmp_b,
  output logic [DATA_W-1:0] sum,
  output logic              equal
);

  assign sum   = opa + opb;
  assign equal = (opa == cmp_b);

endmodule

// File: rtl/mc5_pcgen.sv
module mc5_pcgen #(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 12
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  offset,
  output logic [ADDR_W-1:0] pc_next_slot,
  output logic [ADDR_W-1:0] branch_target
);

  localparam int SLOT_BYTES = 4;

  logic [ADDR_W-1:0] off_ext;

  assign off_ext       = {{(ADDR_W-IMM_W){offset[IMM_W-1]}}, offset};
  assign pc_next_slot  = pc + ADDR_W'(SLOT_BYTES);
  assign branch_target = pc + off_ext;

endmodule

// File: rtl/mc5_core.sv
module mc5_core
  import mc5_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int LINK_IDX = 15
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [INSTR_W-1:0] mem_rdata
);

  step_e step;

  logic [ADDR_W-1:0]  pc_q, pct_q;
  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  ra_q, rb_q, rz_q, rm_q, ry_q;

  logic [OPC_W-1:0]   opc;
  logic [RIDX_W-1:0]  f1, f2, f3;
  logic [IMM_W-1:0]   imm;
  logic [DATA_W-1:0]  imm_ext;

  assign opc     = ir_q[OPC_LSB +: OPC_W];
  assign f1      = ir_q[F1_LSB +: RIDX_W];
  assign f2      = ir_q[F2_LSB +: RIDX_W];
  assign f3      = ir_q[F3_LSB +: RIDX_W];
  assign imm     = ir_q[IMM_W-1:0];
  assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  // Step sequencing
  mc5_stepper u_step (
    .clk  (clk),
    .rst  (rst),
    .step (step)
  );

  // Register file
  logic [RIDX_W-1:0] rf_b_idx, rf_w_idx;
  logic [DATA_W-1:0] rf_a, rf_b;
  logic              rf_we;

  assign rf_b_idx = (opc == OP_ADD) ? f3 : f1;
  assign rf_w_idx = (opc == OP_CALL) ? RIDX_W'(LINK_IDX) : f1;
  assign rf_we    = (step == S_WB) && writes_reg(opc);

  mc5_regfile #(
    .DATA_W (DATA_W),
    .AW     (RIDX_W)
  ) u_rf (
    .clk      (clk),
    .rst      (rst),
    .rd_a_idx (f2),
    .rd_b_idx (rf_b_idx),
    .rd_a     (rf_a),
    .rd_b     (rf_b),
    .we       (rf_we),
    .wr_idx   (rf_w_idx),
    .wr_data  (ry_q)
  );

  // ALU: second operand is RB for register add, immediate otherwise
  logic [DATA_W-1:0] alu_b, alu_sum;
  logic              alu_eq;

  assign alu_b = (opc == OP_ADD) ? rb_q : imm_ext;

  mc5_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .opa   (ra_q),
    .opb   (alu_b),
    .cmp_b (rb_q),
    .sum   (alu_sum),
    .equal (alu_eq)
  );

  // Instruction address generator
  logic [ADDR_W-1:0] pc_inc, br_tgt;

  mc5_pcgen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_pcg (
    .pc            (pc_q),
    .offset        (imm),
    .pc_next_slot  (pc_inc),
    .branch_target (br_tgt)
  );

  // Datapath registers, one update group per step
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      pct_q <= '0;
      ir_q  <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
      rz_q  <= '0;
      rm_q  <= '0;
      ry_q  <= '0;
    end else begin
      case (step)
        S_FETCH: begin
          ir_q <= mem_rdata;
          pc_q <= pc_inc;
        end
        S_DECODE: begin
          ra_q <= rf_a;
          rb_q <= rf_b;
        end
        S_EXEC: begin
          case (opc)
            OP_ADD, OP_ADDI, OP_LD: rz_q <= alu_sum;
            OP_ST: begin
              rz_q <= alu_sum;
              rm_q <= rb_q;
            end
            OP_BR:  pc_q <= br_tgt;
            OP_BEQ: if (alu_eq) pc_q <= br_tgt;
            OP_CALL: begin
              pct_q <= pc_q;
              pc_q  <= ADDR_W'(ra_q);
            end
            default: ;
          endcase
        end
        S_MEM: begin
          case (opc)
            OP_ADD, OP_ADDI: ry_q <= rz_q;
            OP_LD:           ry_q <= mem_rdata[DATA_W-1:0];
            OP_CALL:         ry_q <= DATA_W'(pct_q);
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // Shared memory port: address multiplexer picks PC or RZ
  logic data_step;

  assign data_step = (step == S_MEM) && ((opc == OP_LD) || (opc == OP_ST));
  assign mem_addr  = data_step ? ADDR_W'(rz_q) : pc_q;
  assign mem_rd    = (step == S_FETCH) || ((step == S_MEM) && (opc == OP_LD));
  assign mem_wr    = (step == S_MEM) && (opc == OP_ST);
  assign mem_wdata = rm_q;

endmodule

// File: rtl/mc5_core_chk.sv
module mc5_core_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        opc
);

  logic [2:0] ph;
  logic       opc_known;

  always_ff @(posedge clk) begin
    if (rst) ph <= 3'd0;
    else     ph <= (ph == 3'd4) ? 3'd0 : ph + 3'd1;
  end

  assign opc_known = (opc >= 4'd1) && (opc <= 4'd7);

  // R1: first cycle out of reset fetches address zero
  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0) && mem_rd);

  // R2: every fifth cycle is a fetch
  a_r2_fetch_slot: assert property (@(posedge clk) disable iff (rst)
    (ph == 3'd0) |-> mem_rd && !mem_wr);

  // R2: decode, exec and writeback cycles are silent on the port
  a_r2_quiet_slots: assert property (@(posedge clk) disable iff (rst)
    (ph == 3'd1 || ph == 3'd2 || ph == 3'd4) |-> !mem_rd && !mem_wr);

  // R6: writes only in the memory step of a store
  a_r6_write_slot: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (ph == 3'd3) && (opc == 4'd4));

  // R10: undefined opcodes make no access in the memory step
  a_r10_undef_quiet: assert property (@(posedge clk) disable iff (rst)
    ((ph == 3'd3) && !opc_known) |-> !mem_rd && !mem_wr);

  // R11: strobes exclusive, no back-to-back writes
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r11_no_wr_burst: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

endmodule

bind mc5_core mc5_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr),
  .opc      (ir_q[23:20])
);

// File: tb/mc5_core_tb.sv
module mc5_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 256;
  localparam int DATA_BASE  = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [23:0] mem_rdata;

  logic [23:0] mem  [MEM_WORDS];   // memory seen by the core
  logic [23:0] mmem [MEM_WORDS];   // reference model memory
  logic [15:0] mr   [16];          // reference model registers
  logic [15:0] mpc;

  int n_chk = 0;
  int n_bad = 0;
  int p     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc5_core u_dut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= {8'h00, mem_wdata};

  function automatic logic [23:0] enc(input int op, input int a, input int b, input int imm);
    return {4'(op), 4'(a), 4'(b), 12'(imm)};
  endfunction

  function automatic logic [15:0] sx(input logic [11:0] v);
    return {{4{v[11]}}, v};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic emit(input logic [23:0] w);
    mem[p]  = w;
    mmem[p] = w;
    p++;
  endtask

  task automatic emit_filler();
    if ($urandom_range(0, 1) == 0)
      emit(enc(1, $urandom_range(0, 12), $urandom_range(0, 15), $urandom_range(0, 15) << 8));
    else
      emit(enc(2, $urandom_range(0, 12), $urandom_range(0, 15), $urandom_range(0, 4095)));
  endtask

  // Model step: returns next PC, applies register and memory effects
  task automatic model_exec(input logic [23:0] ins);
    logic [3:0]  op, a, b, c;
    logic [15:0] npc, ea, tgt;
    op  = ins[23:20]; a = ins[19:16]; b = ins[15:12]; c = ins[11:8];
    npc = mpc + 16'd4;
    ea  = mr[b] + sx(ins[11:0]);
    case (op)
      4'd1: mr[a] = mr[b] + mr[c];
      4'd2: mr[a] = ea;
      4'd3: mr[a] = mmem[ea[9:2]][15:0];
      4'd4: mmem[ea[9:2]] = {8'h00, mr[a]};
      4'd5: npc = npc + sx(ins[11:0]);
      4'd6: if (mr[a] == mr[b]) npc = npc + sx(ins[11:0]);
      4'd7: begin tgt = mr[b]; mr[15] = npc; npc = tgt; end
      default: ;
    endcase
    mpc = npc;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed_dummy;
    int dump_start, end_pc, guard;
    logic [3:0]  prev_op;
    logic [23:0] ins;
    logic [3:0]  op;
    logic [15:0] ea;
    string ftag;

    seed_dummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem[i]  = 24'($urandom);
      mmem[i] = mem[i];
    end
    for (int i = 0; i < 16; i++) mr[i] = '0;
    mpc = '0;

    // Directed prologue
    emit(enc(2, 14, 14, DATA_BASE));      // r14 = 512 (R4, R1 zeroed regs)
    emit(enc(2, 1, 1, -5));               // negative immediate (R4)
    emit(enc(2, 2, 2, 2047));             // largest positive immediate (R4)
    emit(enc(1, 3, 1, 2 << 8));           // r3 = r1 + r2 (R3)
    emit(enc(4, 3, 14, 0));               // store r3 (R6)
    emit(enc(3, 4, 14, 0));               // reload it (R5)
    emit(enc(15, 5, 6, 12'h123));         // undefined opcode (R10)
    emit(enc(0, 7, 8, 12'h456));          // undefined opcode 0 (R10)
    emit(enc(6, 14, 14, 8));              // equal: taken (R8)
    emit_filler(); emit_filler();
    emit(enc(6, 1, 2, 4));                // not equal: falls through (R8)
    emit_filler();
    emit(enc(5, 0, 0, 4));                // branch over one slot (R7)
    emit_filler();
    emit(enc(2, 13, 14, 4 * (p + 3) - DATA_BASE));
    emit(enc(7, 0, 13, 0));               // call (R9)
    emit_filler();
    emit(enc(1, 0, 15, 0 << 8));          // r0 = r15 + r0 exposes link

    // Random body
    while (p < 100) begin
      int kind, k;
      kind = $urandom_range(0, 9);
      case (kind)
        0, 1, 2, 3: emit_filler();
        4: emit(enc(3, $urandom_range(0, 12), 14, $urandom_range(0, 127) * 4));
        5: emit(enc(4, $urandom_range(0, 15), 14, $urandom_range(0, 127) * 4));
        6: begin
          k = $urandom_range(0, 3);
          emit(enc(5, 0, 0, 4 * k));
          for (int j = 0; j < k; j++) emit_filler();
        end
        7: begin
          k = $urandom_range(0, 3);
          emit(enc(6, $urandom_range(0, 15), $urandom_range(0, 15), 4 * k));
          for (int j = 0; j < k; j++) emit_filler();
        end
        8: begin
          k = $urandom_range(0, 2);
          emit(enc(2, 13, 14, 4 * (p + 2 + k) - DATA_BASE));
          emit(enc(7, 0, 13, 0));
          for (int j = 0; j < k; j++) emit_filler();
        end
        default: begin
          int r;
          r = $urandom_range(0, 8);
          emit(enc((r == 0) ? 0 : r + 7, $urandom_range(0, 15), $urandom_range(0, 15),
                   $urandom_range(0, 4095)));
        end
      endcase
    end

    // Register dump: every register stored to its own slot
    dump_start = 4 * p;
    for (int k = 0; k < 16; k++) emit(enc(4, k, 14, 256 + 4 * k));
    end_pc = 4 * p;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check((mem_addr == 16'h0) && mem_rd && !mem_wr, "R1 fetch at zero after reset",
          {mem_rd, mem_wr, mem_addr}, {2'b10, 16'h0});
    rst = 1'b0;

    prev_op = 4'd0;
    guard   = 0;
    while ((int'(mpc) != end_pc) && (guard < 2000)) begin
      guard++;
      case (prev_op)
        4'd5: ftag = "R7 branch target";
        4'd6: ftag = "R8 conditional branch";
        4'd7: ftag = "R9 call target";
        default: ftag = "R2 fetch address";
      endcase
      check((mem_addr == mpc) && mem_rd && !mem_wr, ftag,
            {mem_rd, mem_wr, mem_addr}, {2'b10, mpc});
      ins = mmem[mpc[9:2]];
      op  = ins[23:20];
      ea  = mr[ins[15:12]] + sx(ins[11:0]);
      repeat (3) @(negedge clk);
      if (op == 4'd3) begin
        check(mem_rd && !mem_wr && (mem_addr == ea), "R5 load access",
              {mem_rd, mem_wr, mem_addr}, {2'b10, ea});
      end else if (op == 4'd4) begin
        check(!mem_rd && mem_wr && (mem_addr == ea) && (mem_wdata == mr[ins[19:16]]),
              (int'(mpc) >= dump_start) ? "R3 R4 R5 R9 R10 register readback via R6 store"
                                        : "R6 store access",
              {mem_wr, mem_addr, mem_wdata}, {1'b1, ea, mr[ins[19:16]]});
      end else begin
        check(!mem_rd && !mem_wr,
              ((op == 0) || (op > 7)) ? "R10 undefined op quiet" : "R11 no data access",
              {mem_rd, mem_wr}, 2'b00);
      end
      model_exec(ins);
      prev_op = op;
      repeat (2) @(negedge clk);
    end
    check(int'(mpc) == end_pc, "R2 program completed", mpc, end_pc);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule